// File: doc/BRIEF.md
# Pin Level and Input Sampling Resolver

This block works out, for each pin of a general-purpose I/O bank, the level the pin settles to and the value that software sees when it reads the input. It combines the stored controls: output data, output enable, output type (push-pull or open-drain), polarity, pull-up and pull-down selects, and input enable. The pin is modelled as internal with no outside driver. Its level therefore follows from these controls alone, and the read value can be predicted exactly.

Polarity acts twice. It inverts the value sent towards the pin, and it inverts the sampled value on the way back. A push-pull output therefore reads back its own data-out. The open-drain release decision is taken on the value after inversion. A pin that is released or not enabled takes its pull level. Input masking forces the sample to zero before the return inversion. The logic is purely combinational, so the outputs follow the control vectors in the same cycle and a register read in the next cycle sees them.

Top module: `pin_resolver`

## Requirements
- R1: The value sent towards each pin is data-out XOR polarity. With output enable set and push-pull type (type bit 0), the pin equals that value.
- R2: For a bit in push-pull type with output enable set, the pull-up and pull-down bits have no effect on the pin level or on the read value.
- R3: For a bit in open-drain type (type bit 1) with output enable set and a sent value of 0, the pin is 0 and the driver indicator is 1.
- R4: For a bit in open-drain type with output enable set and a sent value of 1, the driver indicator is 0 and the pin takes the pull level.
- R5: With output enable clear, the driver indicator is 0 and the pin takes the pull level, whatever the output type and data-out.
- R6: When pull-down is the inverse of pull-up on an undriven pin, the pin equals the pull-up bit.
- R7: When pull-up and pull-down are equal on an undriven pin, the default policy (pull-up wins) makes the pin equal the pull-up bit.
- R8: The read value is (pin AND input-enable) XOR polarity. A bit with input enable 0 reads as its polarity bit.
- R9: The driver indicator is 1 exactly when output enable is set and the bit is either push-pull or sending 0.
- R10: With all controls zero, the pin, the driver indicator and the read value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dout_i | input | WIDTH | Output data per pin |
| oe_i | input | WIDTH | Output enable per pin |
| odrain_i | input | WIDTH | Output type, 1 = open-drain |
| inv_i | input | WIDTH | Polarity inversion per pin |
| pullup_i | input | WIDTH | Pull-up select |
| pulldn_i | input | WIDTH | Pull-down select |
| inen_i | input | WIDTH | Input enable, 0 masks the sample |
| pin_o | output | WIDTH | Resolved pin level |
| driving_o | output | WIDTH | 1 where the output driver is active |
| din_o | output | WIDTH | Read value after masking and inversion |

## Verification
Open-drain release and the return path can meet on one bit in the same cycle. A bit sending 1 through inversion floats to its pull level, and that level is then masked or not and inverted again on the way back. The sweep gives every bit of a narrow bank a different one of all 128 combinations of the seven control bits, and it rotates the assignment each step. Every pairing of release, pull conflict, mask and polarity thus appears together. Each output bit is judged against an arithmetic model, grouped by the case that applies to that bit.

// File: rtl/pinres_pkg.sv
package pinres_pkg;

   // How an undriven pin settles when both pull selects agree
   typedef enum logic {
      TIE_PULLUP = 1'b0,   // level follows the pull-up bit
      TIE_LOW    = 1'b1    // level is 1 only with pull-up alone
   } tie_policy_e;

   localparam int unsigned MAX_WIDTH = 1024;

endpackage

// File: rtl/pinres_drive.sv
module pinres_drive #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] dout_i,
   input  logic [WIDTH-1:0] oe_i,
   input  logic [WIDTH-1:0] odrain_i,
   input  logic [WIDTH-1:0] inv_i,
   output logic [WIDTH-1:0] sent_o,
   output logic [WIDTH-1:0] drive_en_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic sent;
      logic releases;
      assign sent     = dout_i[b] ^ inv_i[b];
      // open-drain lets go of the pin when the inverted value is high
      assign releases = odrain_i[b] & sent;
      assign sent_o[b]     = sent;
      assign drive_en_o[b] = oe_i[b] & ~releases;
   end
endmodule

// File: rtl/pinres_pull.sv
module pinres_pull
   import pinres_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter tie_policy_e POLICY = TIE_PULLUP
) (
   input  logic [WIDTH-1:0] pullup_i,
   input  logic [WIDTH-1:0] pulldn_i,
   output logic [WIDTH-1:0] float_o
);
   if (POLICY == TIE_PULLUP) begin : g_up
      // complementary or not, the pull-up bit decides
      assign float_o = pullup_i;
   end else begin : g_low
      assign float_o = pullup_i & ~pulldn_i;
   end
endmodule

// File: rtl/pinres_sample.sv
module pinres_sample #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] pin_i,
   input  logic [WIDTH-1:0] inen_i,
   input  logic [WIDTH-1:0] inv_i,
   output logic [WIDTH-1:0] din_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic gated;
      assign gated    = pin_i[b] & inen_i[b];
      assign din_o[b] = gated ^ inv_i[b];
   end
endmodule

// File: rtl/pin_resolver.sv
module pin_resolver
   import pinres_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter tie_policy_e POLICY = TIE_PULLUP
) (
   input  logic [WIDTH-1:0] dout_i,
   input  logic [WIDTH-1:0] oe_i,
   input  logic [WIDTH-1:0] odrain_i,
   input  logic [WIDTH-1:0] inv_i,
   input  logic [WIDTH-1:0] pullup_i,
   input  logic [WIDTH-1:0] pulldn_i,
   input  logic [WIDTH-1:0] inen_i,
   output logic [WIDTH-1:0] pin_o,
   output logic [WIDTH-1:0] driving_o,
   output logic [WIDTH-1:0] din_o
);
   if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("pin_resolver: WIDTH out of range");
   end

   logic [WIDTH-1:0] sent;
   logic [WIDTH-1:0] drive_en;
   logic [WIDTH-1:0] float_lvl;
   logic [WIDTH-1:0] pin;

   pinres_drive #(.WIDTH(WIDTH)) u_drive (
      .dout_i     (dout_i),
      .oe_i       (oe_i),
      .odrain_i   (odrain_i),
      .inv_i      (inv_i),
      .sent_o     (sent),
      .drive_en_o (drive_en)
   );

   pinres_pull #(.WIDTH(WIDTH), .POLICY(POLICY)) u_pull (
      .pullup_i (pullup_i),
      .pulldn_i (pulldn_i),
      .float_o  (float_lvl)
   );

   assign pin = (drive_en & sent) | (~drive_en & float_lvl);

   pinres_sample #(.WIDTH(WIDTH)) u_sample (
      .pin_i  (pin),
      .inen_i (inen_i),
      .inv_i  (inv_i),
      .din_o  (din_o)
   );

   assign pin_o     = pin;
   assign driving_o = drive_en;
endmodule

// File: rtl/pin_resolver_chk.sv
module pin_resolver_chk
   import pinres_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter tie_policy_e POLICY = TIE_PULLUP
) (
   input logic [WIDTH-1:0] dout_i,
   input logic [WIDTH-1:0] oe_i,
   input logic [WIDTH-1:0] odrain_i,
   input logic [WIDTH-1:0] inv_i,
   input logic [WIDTH-1:0] pullup_i,
   input logic [WIDTH-1:0] pulldn_i,
   input logic [WIDTH-1:0] inen_i,
   input logic [WIDTH-1:0] pin_o,
   input logic [WIDTH-1:0] driving_o,
   input logic [WIDTH-1:0] din_o
);
   logic [WIDTH-1:0] pull_ref;
   assign pull_ref = (POLICY == TIE_PULLUP) ? pullup_i : (pullup_i & ~pulldn_i);

   always_comb begin
      // R1
      pp_drive_chk: assert (((oe_i & ~odrain_i) & (pin_o ^ dout_i ^ inv_i)) == '0);
      // R3
      od_low_chk: assert (((oe_i & odrain_i & ~(dout_i ^ inv_i)) & pin_o) == '0);
      // R5
      idle_pull_chk: assert ((~oe_i & (pin_o ^ pull_ref)) == '0);
      // R8
      masked_read_chk: assert ((~inen_i & (din_o ^ inv_i)) == '0);
      // R9
      drive_needs_oe_chk: assert ((driving_o & ~oe_i) == '0);
      // R2
      pp_readback_chk: assert (((oe_i & ~odrain_i & inen_i) & (din_o ^ dout_i)) == '0);
   end
endmodule

bind pin_resolver pin_resolver_chk #(.WIDTH(WIDTH), .POLICY(POLICY)) u_pin_resolver_chk (
   .dout_i    (dout_i),
   .oe_i      (oe_i),
   .odrain_i  (odrain_i),
   .inv_i     (inv_i),
   .pullup_i  (pullup_i),
   .pulldn_i  (pulldn_i),
   .inen_i    (inen_i),
   .pin_o     (pin_o),
   .driving_o (driving_o),
   .din_o     (din_o)
);

// File: tb/test_pin_resolver.sv
`timescale 1ns/1ps
module test_pin_resolver;
   import pinres_pkg::*;

   localparam int unsigned W = 8;
   localparam realtime HALF = 2.0;

   logic clk = 1'b0;
   always #(HALF) clk = ~clk;

   logic [W-1:0] dout = '0, oe = '0, od = '0, inv = '0, pu = '0, pd = '0, ie = '0;
   logic [W-1:0] pin, drv, din;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   pin_resolver #(.WIDTH(W), .POLICY(TIE_PULLUP)) i_pin_resolver (
      .dout_i (dout), .oe_i (oe), .odrain_i (od), .inv_i (inv),
      .pullup_i (pu), .pulldn_i (pd), .inen_i (ie),
      .pin_o (pin), .driving_o (drv), .din_o (din)
   );

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp,
                      input logic [W-1:0] mask);
      n_chk++;
      if ((got & mask) !== (exp & mask)) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h (bits %h)", tag, got & mask, exp & mask, mask);
      end
   endtask

   // apply controls on a rising edge, judge at the following falling edge
   task automatic apply(input logic [W-1:0] d, o, t, p, u, l, e);
      @(posedge clk);
      dout = d; oe = o; od = t; inv = p; pu = u; pd = l; ie = e;
      @(negedge clk);
   endtask

   // arithmetic model plus case masks, then compare
   task automatic judge();
      logic [W-1:0] e_pin, e_drv, e_din;
      logic [W-1:0] m_pp, m_odl, m_odf, m_idle, m_comp, m_conf;
      for (int b = 0; b < W; b++) begin
         logic s, en, fl;
         s  = dout[b] ^ inv[b];
         en = oe[b] & (~od[b] | ~s);
         fl = pu[b];
         e_drv[b] = en;
         e_pin[b] = en ? s : fl;
         e_din[b] = (e_pin[b] & ie[b]) ^ inv[b];
         m_pp[b]   = oe[b] & ~od[b];
         m_odl[b]  = oe[b] & od[b] & ~s;
         m_odf[b]  = oe[b] & od[b] & s;
         m_idle[b] = ~oe[b];
         m_comp[b] = ~en & (pu[b] ^ pd[b]);
         m_conf[b] = ~en & ~(pu[b] ^ pd[b]);
      end
      chk("R1 pin push-pull", pin, e_pin, m_pp);
      chk("R3 pin open-drain low", pin, e_pin, m_odl);
      chk("R3 driver open-drain low", drv, e_drv, m_odl);
      chk("R4 pin open-drain released", pin, e_pin, m_odf);
      chk("R4 driver open-drain released", drv, e_drv, m_odf);
      chk("R5 pin output disabled", pin, e_pin, m_idle);
      chk("R6 pin complementary pulls", pin, e_pin, m_comp);
      chk("R7 pin conflicting pulls", pin, e_pin, m_conf);
      chk("R8 read value", din, e_din, '1);
      chk("R9 driver indicator", drv, e_drv, '1);
   endtask

   initial begin
      // R10: all-zero controls
      @(negedge clk);
      chk("R10 pin at zero", pin, '0, '1);
      chk("R10 driver at zero", drv, '0, '1);
      chk("R10 read at zero", din, '0, '1);

      // R2: push-pull ignores pulls, flip pulls and read again
      apply(8'hA5, 8'hFF, 8'h00, 8'h0F, 8'hFF, 8'h00, 8'hFF);
      chk("R2 pin with pull-up", pin, 8'hAA, '1);
      chk("R2 read with pull-up", din, 8'hA5, '1);
      apply(8'hA5, 8'hFF, 8'h00, 8'h0F, 8'h00, 8'hFF, 8'hFF);
      chk("R2 pin with pull-down", pin, 8'hAA, '1);
      chk("R2 read with pull-down", din, 8'hA5, '1);

      // R8: masked input reads polarity
      apply(8'hFF, 8'hFF, 8'h00, 8'h3C, 8'hFF, 8'h00, 8'h00);
      chk("R8 masked read", din, 8'h3C, '1);

      // R4/R6: open-drain release with complementary pulls
      apply(8'hF0, 8'hFF, 8'hFF, 8'h00, 8'hCC, 8'h33, 8'hFF);
      chk("R4 released nibble follows pull", pin, 8'hC0, '1);

      // sweep: each bit a distinct combination of the seven controls
      for (int k = 0; k < 128; k++) begin
         logic [W-1:0] v [7];
         for (int b = 0; b < W; b++) begin
            int c;
            c = (k + 16 * b) % 128;
            for (int f = 0; f < 7; f++) v[f][b] = c[f];
         end
         apply(v[0], v[1], v[2], v[3], v[4], v[5], v[6]);
         judge();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(HALF * 2 * 20000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule